// File: doc/BRIEF.md
# Panel Self-Refresh Link Sequencer

This block runs on the source side of a display link. It moves the link between normal refresh and panel self-refresh, where the panel keeps showing a frame from its own buffer. Software controls it through single-cycle request pulses: enable, disable, activate and exit. The block makes the automatic steps on its own. These are the static-frame entry, the return to inactive after an exit, and entry from an idle-frame count when auto mode is on. A per-frame strobe and a frame-changed flag from the pixel pipeline drive the frame-based steps.

The current step is reported as a three-bit state number. Each exit is closed by a one-byte wake write to the sink, placed on an external AUX transaction port. The block waits for that port's done pulse before it reports inactive again. A disable request that lands during an automatic step waits for the step to finish. If it waits too long, the block raises an error and forces itself off.

Top module: `srf_seq`

## Requirements
- R1: After reset, state_o is 0 (off), and sr_active, in_trans, aux_req and timeout_err are all low.
- R2: The state numbers are 0 off, 1 inactive, 2 entering, 3 active with the panel buffer frozen, 4 active with a one-frame update, and 5 exiting. An enable request in state 0 gives state 1 at the next clock edge. In any other state it is dropped. Frame strobes alone never leave state 1 while auto_mode is low.
- R3: An activate request in state 1 gives state 2. State 2 moves to state 3 at the next frame_tick, with no further request. An activate request outside state 1 is dropped.
- R4: An exit request in state 3 or state 4 gives state 5 directly, so state 4 is never entered on the way out. An exit request in states 0 or 1 is dropped.
- R5: In state 5, aux_req is high with aux_addr = 0x600 and aux_wdata = 0x01. The block stays in state 5 until aux_done is high, and goes to state 1 at that edge.
- R6: sr_active is high only in states 3 and 4. A frame_tick together with frame_changed in state 3 gives state 4. The next frame_tick in state 4 gives state 3 again.
- R7: in_trans is high in states 2 and 5. A request that arrives while in_trans is high is held. It takes effect at the first clock edge where in_trans is low; for example, an exit requested in state 2 gives state 5 one cycle after state 3 is reached.
- R8: A disable request gives state 0 at the next edge when in_trans is low. Otherwise it waits. If in_trans stays high for TIMEOUT_CYC edges, counted from the edge of the request, the block goes to state 0 with timeout_err set. timeout_err stays set until an enable request is accepted.
- R9: With auto_mode high in state 1, the block goes to state 2 on the frame_tick that completes N unchanged frames in a row. N is idle_cfg + 1, or 2 when idle_cfg is 0.
- R10: frame_changed while counting in state 1 clears the unchanged-frame count to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en_req | input | 1 | Enable request pulse |
| dis_req | input | 1 | Disable request pulse |
| act_req | input | 1 | Activate request pulse |
| exit_req | input | 1 | Exit request pulse |
| auto_mode | input | 1 | Allow entry from the idle-frame count |
| idle_cfg | input | CFG_W | Configured idle-frame count |
| frame_tick | input | 1 | One pulse per frame |
| frame_changed | input | 1 | Current frame differs from the last one |
| aux_req | output | 1 | Wake write request to the AUX port |
| aux_addr | output | ADDR_W | Sink address of the wake write |
| aux_wdata | output | 8 | Byte carried by the wake write |
| aux_done | input | 1 | AUX port completion pulse |
| state_o | output | 3 | Current state number |
| sr_active | output | 1 | Self-refresh active |
| in_trans | output | 1 | An automatic step is in progress |
| timeout_err | output | 1 | A disable wait timed out |

## Verification
The bench builds the block with CFG_W = 4 and TIMEOUT_CYC = 8. The short timeout lets the bench run one full expiry in state 5, with aux_done held back, and check the cycles just before and at the limit. A 4-bit idle_cfg covers both threshold forms, the 2-frame minimum for a zero setting and the setting-plus-one case with 3. It also keeps the count runs short enough to break one with frame_changed and then finish it.

// File: rtl/srf_pkg.sv
package srf_pkg;

   typedef enum logic [2:0] {
      ST_OFF   = 3'd0,
      ST_IDLE  = 3'd1,
      ST_ENTRY = 3'd2,
      ST_HOLD  = 3'd3,
      ST_SFU   = 3'd4,
      ST_WAKE  = 3'd5
   } srf_state_e;

endpackage

// File: rtl/srf_idle_cnt.sv
module srf_idle_cnt #(
   parameter int CFG_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             arm,
   input  logic             frame_tick,
   input  logic             frame_changed,
   input  logic [CFG_W-1:0] idle_cfg,
   output logic             reach
);
   localparam int CNT_W = CFG_W + 1;

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] thr;

   // Threshold is the setting plus one, with a floor of two frames.
   assign thr   = (idle_cfg == '0) ? CNT_W'(2) : (CNT_W'(idle_cfg) + CNT_W'(1));
   assign reach = arm && frame_tick && !frame_changed && ((cnt + CNT_W'(1)) >= thr);

   always_ff @(posedge clk) begin
      if (!rst_n || !arm) begin
         cnt <= '0;
      end else if (frame_changed) begin
         cnt <= '0;
      end else if (frame_tick) begin
         cnt <= reach ? '0 : cnt + CNT_W'(1);
      end
   end

   // R10: a changed frame wipes the running count
   assert_clear_on_change_R10 : assert property (@(posedge clk) disable iff (!rst_n)
      (arm && frame_changed) |=> (cnt == '0));

endmodule

// File: rtl/srf_wait_timer.sv
module srf_wait_timer #(
   parameter int LIMIT = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic expire
);
   localparam int W = $clog2(LIMIT + 1);

   logic [W-1:0] tmr;

   assign expire = run && (tmr == W'(LIMIT - 1));

   always_ff @(posedge clk) begin
      if (!rst_n || !run || expire) begin
         tmr <= '0;
      end else begin
         tmr <= tmr + W'(1);
      end
   end

   // R8: the wait counter never passes its limit
   assert_tmr_bound_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      tmr < W'(LIMIT));

endmodule

// File: rtl/srf_seq.sv
module srf_seq
   import srf_pkg::*;
#(
   parameter int                CFG_W       = 4,
   parameter int                TIMEOUT_CYC = 16,
   parameter int                ADDR_W      = 20,
   parameter logic [ADDR_W-1:0] WAKE_ADDR   = 20'h00600,
   parameter logic [7:0]        WAKE_DATA   = 8'h01
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_req,
   input  logic              dis_req,
   input  logic              act_req,
   input  logic              exit_req,
   input  logic              auto_mode,
   input  logic [CFG_W-1:0]  idle_cfg,
   input  logic              frame_tick,
   input  logic              frame_changed,
   output logic              aux_req,
   output logic [ADDR_W-1:0] aux_addr,
   output logic [7:0]        aux_wdata,
   input  logic              aux_done,
   output logic [2:0]        state_o,
   output logic              sr_active,
   output logic              in_trans,
   output logic              timeout_err
);

   generate
      if (TIMEOUT_CYC < 2) begin : g_bad_timeout
         $error("srf_seq: TIMEOUT_CYC must be at least 2");
      end
      if (CFG_W < 1) begin : g_bad_cfg
         $error("srf_seq: CFG_W must be at least 1");
      end
      if (ADDR_W < 12) begin : g_bad_addr
         $error("srf_seq: ADDR_W too narrow for the wake address");
      end
   endgenerate

   srf_state_e state_q, state_d;
   logic en_pend, dis_pend, act_pend, exit_pend;
   logic en_eff, dis_eff, act_eff, exit_eff;
   logic auto_hit, tmo_expire, err_q, set_err, clr_err;

   assign in_trans = (state_q == ST_ENTRY) || (state_q == ST_WAKE);
   assign en_eff   = en_req   || en_pend;
   assign dis_eff  = dis_req  || dis_pend;
   assign act_eff  = act_req  || act_pend;
   assign exit_eff = exit_req || exit_pend;

   srf_idle_cnt #(.CFG_W(CFG_W)) u_idle (
      .clk           (clk),
      .rst_n         (rst_n),
      .arm           (auto_mode && (state_q == ST_IDLE)),
      .frame_tick    (frame_tick),
      .frame_changed (frame_changed),
      .idle_cfg      (idle_cfg),
      .reach         (auto_hit)
   );

   srf_wait_timer #(.LIMIT(TIMEOUT_CYC)) u_wait (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (in_trans && dis_eff),
      .expire (tmo_expire)
   );

   always_comb begin
      state_d = state_q;
      set_err = 1'b0;
      clr_err = 1'b0;
      if (tmo_expire) begin
         state_d = ST_OFF;
         set_err = 1'b1;
      end else if (in_trans) begin
         if (state_q == ST_ENTRY && frame_tick) state_d = ST_HOLD;
         if (state_q == ST_WAKE && aux_done)    state_d = ST_IDLE;
      end else if (dis_eff && state_q != ST_OFF) begin
         state_d = ST_OFF;
      end else begin
         case (state_q)
            ST_OFF:  if (en_eff) begin
                        state_d = ST_IDLE;
                        clr_err = 1'b1;
                     end
            ST_IDLE: if (act_eff || auto_hit) state_d = ST_ENTRY;
            ST_HOLD: if (exit_eff) state_d = ST_WAKE;
                     else if (frame_tick && frame_changed) state_d = ST_SFU;
            ST_SFU:  if (exit_eff) state_d = ST_WAKE;
                     else if (frame_tick) state_d = ST_HOLD;
            default: state_d = state_q;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q   <= ST_OFF;
         err_q     <= 1'b0;
         en_pend   <= 1'b0;
         dis_pend  <= 1'b0;
         act_pend  <= 1'b0;
         exit_pend <= 1'b0;
      end else begin
         state_q <= state_d;
         if (set_err)      err_q <= 1'b1;
         else if (clr_err) err_q <= 1'b0;
         if (in_trans && !tmo_expire) begin
            en_pend   <= en_eff;
            dis_pend  <= dis_eff;
            act_pend  <= act_eff;
            exit_pend <= exit_eff;
         end else begin
            en_pend   <= 1'b0;
            dis_pend  <= 1'b0;
            act_pend  <= 1'b0;
            exit_pend <= 1'b0;
         end
      end
   end

   assign state_o     = state_q;
   assign sr_active   = (state_q == ST_HOLD) || (state_q == ST_SFU);
   assign aux_req     = (state_q == ST_WAKE);
   assign aux_addr    = WAKE_ADDR;
   assign aux_wdata   = WAKE_DATA;
   assign timeout_err = err_q;

   // R2: leaving the off state only ever lands on inactive
   assert_enable_to_idle_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_OFF) |=> (state_q == ST_OFF || state_q == ST_IDLE));

   // R3: self-refresh becomes active only out of the entering step
   assert_entry_path_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sr_active) |-> ($past(state_q) == ST_ENTRY));

   // R4: an exit from the frozen state goes straight to exiting
   assert_exit_skips_sfu_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_HOLD && exit_req && !dis_req) |=> (state_q == ST_WAKE));

   // R5: exiting is left only on the wake write acknowledge or a timeout
   assert_wake_ack_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_WAKE && !aux_done && !tmo_expire) |=> (state_q == ST_WAKE));

   // R7: an exit seen during an automatic step is held
   assert_exit_held_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      (in_trans && exit_req) |=> (exit_pend || state_q == ST_OFF));

endmodule

// File: tb/srf_seq_bench.sv
module srf_seq_bench;

   typedef struct {
      int         due;
      logic [2:0] st;
      logic       er;
      string      tag;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        en_req = 0, dis_req = 0, act_req = 0, exit_req = 0;
   logic        auto_mode = 0, frame_tick = 0, frame_changed = 0, aux_done = 0;
   logic [3:0]  idle_cfg = 4'd0;
   logic        aux_req, sr_active, in_trans, timeout_err;
   logic [19:0] aux_addr;
   logic [7:0]  aux_wdata;
   logic [2:0]  state_o;

   int   cyc = 0;
   int   tests = 0;
   int   fails = 0;
   exp_t q[$];
   exp_t cur;

   always #5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   srf_seq #(.CFG_W(4), .TIMEOUT_CYC(8)) u_srf_seq (
      .clk(clk), .rst_n(rst_n), .en_req(en_req), .dis_req(dis_req),
      .act_req(act_req), .exit_req(exit_req), .auto_mode(auto_mode),
      .idle_cfg(idle_cfg), .frame_tick(frame_tick), .frame_changed(frame_changed),
      .aux_req(aux_req), .aux_addr(aux_addr), .aux_wdata(aux_wdata),
      .aux_done(aux_done), .state_o(state_o), .sr_active(sr_active),
      .in_trans(in_trans), .timeout_err(timeout_err)
   );

   // Monitor: compares queued expectations once outputs have settled.
   always @(negedge clk) begin
      #1;
      while (q.size() > 0 && q[0].due == cyc) begin
         logic ea, et;
         cur = q.pop_front();
         ea = (cur.st == 3'd3) || (cur.st == 3'd4);
         et = (cur.st == 3'd2) || (cur.st == 3'd5);
         tests++;
         if (state_o !== cur.st || sr_active !== ea || in_trans !== et ||
             aux_req !== (cur.st == 3'd5) || timeout_err !== cur.er) begin
            fails++;
            $display("FAIL %s: got st=%0d act=%0b trn=%0b aux=%0b err=%0b, expected st=%0d act=%0b trn=%0b aux=%0b err=%0b",
                     cur.tag, state_o, sr_active, in_trans, aux_req, timeout_err,
                     cur.st, ea, et, (cur.st == 3'd5), cur.er);
         end
      end
   end

   task automatic chk(input logic [2:0] st, input logic er, input string tag);
      exp_t e;
      e.due = cyc; e.st = st; e.er = er; e.tag = tag;
      q.push_back(e);
   endtask

   task automatic drive(input logic e, input logic d, input logic a, input logic x,
                        input logic t, input logic c, input logic dn);
      en_req = e; dis_req = d; act_req = a; exit_req = x;
      frame_tick = t; frame_changed = c; aux_done = dn;
      @(negedge clk);
      en_req = 0; dis_req = 0; act_req = 0; exit_req = 0;
      frame_tick = 0; frame_changed = 0; aux_done = 0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      #2_000_000;
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      chk(3'd0, 0, "R1 reset state");
      //         e d a x t c dn
      drive(0,0,1,0,0,0,0); chk(3'd0, 0, "R3 activate ignored when off");
      drive(0,0,0,1,0,0,0); chk(3'd0, 0, "R4 exit ignored when off");
      drive(1,0,0,0,0,0,0); chk(3'd1, 0, "R2 enable to inactive");
      for (int i = 0; i < 3; i++) begin
         drive(0,0,0,0,1,0,0); chk(3'd1, 0, "R2 no entry without request");
      end
      drive(1,0,0,0,0,0,0); chk(3'd1, 0, "R2 enable ignored when on");
      drive(0,0,0,1,0,0,0); chk(3'd1, 0, "R4 exit ignored in inactive");
      drive(0,0,1,0,0,0,0); chk(3'd2, 0, "R3 activate to entering");
      drive(0,0,0,1,0,0,0); chk(3'd2, 0, "R7 exit held during entry");
      drive(0,0,0,0,1,0,0); chk(3'd3, 0, "R3 frame moves entering to active");
      idle(1);              chk(3'd5, 0, "R7 held exit applied");
      tests++;
      if (aux_addr !== 20'h00600 || aux_wdata !== 8'h01) begin
         fails++;
         $display("FAIL R5 wake write: got addr=%h data=%h, expected addr=00600 data=01",
                  aux_addr, aux_wdata);
      end
      idle(3);              chk(3'd5, 0, "R5 waits for aux done");
      drive(0,0,0,0,0,0,1); chk(3'd1, 0, "R5 aux done returns to inactive");
      drive(0,0,1,0,0,0,0); chk(3'd2, 0, "R3 activate again");
      drive(0,0,0,0,1,0,0); chk(3'd3, 0, "R6 active frozen");
      drive(0,0,0,0,1,1,0); chk(3'd4, 0, "R6 changed frame to single update");
      drive(0,0,0,0,1,0,0); chk(3'd3, 0, "R6 back to frozen");
      drive(0,0,0,0,1,1,0); chk(3'd4, 0, "R6 single update again");
      drive(0,0,0,1,0,0,0); chk(3'd5, 0, "R4 exit from single update");
      drive(0,0,0,0,0,0,1); chk(3'd1, 0, "R5 acknowledge");
      drive(0,1,0,0,0,0,0); chk(3'd0, 0, "R8 disable from inactive");
      drive(1,0,0,0,0,0,0); chk(3'd1, 0, "R2 re-enable");
      drive(0,0,1,0,0,0,0); chk(3'd2, 0, "R3 entering");
      drive(0,1,0,0,0,0,0); chk(3'd2, 0, "R8 disable waits during entry");
      drive(0,0,0,0,1,0,0); chk(3'd3, 0, "R8 step completes first");
      idle(1);              chk(3'd0, 0, "R8 held disable applied");
      // timeout case
      drive(1,0,0,0,0,0,0); chk(3'd1, 0, "R2 enable");
      drive(0,0,1,0,0,0,0); chk(3'd2, 0, "R3 entering");
      drive(0,0,0,0,1,0,0); chk(3'd3, 0, "R3 active");
      drive(0,0,0,1,0,0,0); chk(3'd5, 0, "R4 exiting");
      drive(0,1,0,0,0,0,0); chk(3'd5, 0, "R8 disable held in exiting");
      idle(6);              chk(3'd5, 0, "R8 one edge before timeout");
      idle(1);              chk(3'd0, 1, "R8 timeout forces off with error");
      drive(1,0,0,0,0,0,0); chk(3'd1, 0, "R8 enable clears error");
      // auto entry, threshold 4
      auto_mode = 1; idle_cfg = 4'd3;
      for (int i = 0; i < 3; i++) begin
         drive(0,0,0,0,1,0,0); chk(3'd1, 0, "R9 counting idle frames");
      end
      drive(0,0,0,0,1,0,0); chk(3'd2, 0, "R9 auto entry at setting plus one");
      drive(0,0,0,0,1,0,0); chk(3'd3, 0, "R3 active");
      drive(0,0,0,1,0,0,0); chk(3'd5, 0, "R4 exiting");
      drive(0,0,0,0,0,0,1); chk(3'd1, 0, "R5 inactive");
      drive(0,0,0,0,1,0,0); chk(3'd1, 0, "R10 count 1");
      drive(0,0,0,0,1,0,0); chk(3'd1, 0, "R10 count 2");
      drive(0,0,0,0,1,1,0); chk(3'd1, 0, "R10 changed frame clears");
      for (int i = 0; i < 3; i++) begin
         drive(0,0,0,0,1,0,0); chk(3'd1, 0, "R10 recount after clear");
      end
      drive(0,0,0,0,1,0,0); chk(3'd2, 0, "R10 entry after full recount");
      drive(0,0,0,0,1,0,0); chk(3'd3, 0, "R3 active");
      drive(0,0,0,1,0,0,0); chk(3'd5, 0, "R4 exiting");
      drive(0,0,0,0,0,0,1); chk(3'd1, 0, "R5 inactive");
      // zero setting: threshold 2
      idle_cfg = 4'd0;
      drive(0,0,0,0,1,0,0); chk(3'd1, 0, "R9 zero setting first frame");
      drive(0,0,0,0,1,0,0); chk(3'd2, 0, "R9 zero setting enters after two");
      drive(0,1,0,0,0,0,0); chk(3'd2, 0, "R8 disable waits");
      drive(0,0,0,0,1,0,0); chk(3'd3, 0, "R3 active");
      idle(1);              chk(3'd0, 0, "R8 disable applied");
      idle(2);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule